// File: doc/BRIEF.md
# Parallel printer port register interface

This block is a standard-mode parallel printer port seen from a host register bus. The host reaches three byte registers: an output/input data register, a status register and a control register. A built-in printer model answers the host's handshake, so no external printer model is needed. When the host raises the strobe bit in the control register, the latched data byte is handed to a byte-output stream with a valid/ready handshake. Successive status reads walk the busy/acknowledge handshake forward, and an interrupt line follows the interrupt enable and the acknowledge state.

The register index is the bus address shifted right by the `ADDR_SHIFT` parameter, so the same eight-location window can sit on a byte-packed I/O map or on a word-strided memory-mapped map. Reads return data one cycle after the read strobe. The output stream holds one byte: `out_valid` stays high and `out_data` stays fixed until `out_ready` is seen high at a clock edge. A byte produced while an earlier byte still waits for acceptance is discarded; a byte produced in the same cycle that the waiting one is accepted takes its place.

Top module: `ppt_regif`

## Requirements
- R1: After reset the status register reads 0xD9, the control register reads 0x0C, `irq` is low and `out_valid` is low.
- R2: Register index 0 is the data register: when control bit 5 (direction) is 0 a read returns the last byte written to index 0; when it is 1 a read returns `in_data`.
- R3: Register index 2 is the control register and reads back the last byte written to it.
- R4: A control write with bit 2 (init) equal to 0 sets the status to 0xD8 (busy-complement bit 7, acknowledge bit 6, online bit 4, error-complement bit 3 set; all others clear).
- R5: A control write with bit 2 (init), bit 3 (select) and bit 0 (strobe) all set clears status bit 7; if the strobe bit held 0 before the write, the data byte is emitted exactly once on the output stream, otherwise nothing is emitted.
- R6: A status read (index 1) while status bit 7 and control bit 0 are both 0 steps the handshake: acknowledge bit 6 set is cleared; bit 6 clear sets both bits 6 and 7. The value returned is the status after the step.
- R7: A status read while status bit 7 or control bit 0 is set leaves the status unchanged.
- R8: `irq` is high exactly when control bit 4 (interrupt enable) is set and status bit 6 is clear, updated at the edge of the control write or status read that changes either.
- R9: Once `out_valid` rises it stays high with `out_data` unchanged until accepted with `out_ready`; a byte produced while one is still waiting is dropped.
- R10: Indices 3 to 7 read 0xFF and writes to them change nothing; writes to the status register change nothing.
- R11: The index is the address shifted right by `ADDR_SHIFT` (low address bits below the shift are ignored); addresses at or above 8 shifted locations read 0xFF and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| in_data | input | 8 | Byte presented on the port in input direction |
| out_valid | output | 1 | Output stream byte valid |
| out_ready | input | 1 | Output stream consumer ready |
| out_data | output | 8 | Output stream byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take for granted that the host never raises `bus_rd` and `bus_wr` in the same cycle, since the handshake step and the control update are ordered on that assumption; the bench issues every access as a one-cycle strobe separated from the next. They also assume the consumer changes `out_ready` only between edges, which the bench honours by driving all inputs on the falling edge. The stream is stalled and released from the bench to exercise the hold and drop behaviour, and the address window is tested with a non-zero shift so that sub-stride and out-of-window addresses are reachable.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;

  // register indices
  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd2;

  // status bit positions
  localparam int unsigned ST_NBUSY  = 7;
  localparam int unsigned ST_ACK    = 6;
  localparam int unsigned ST_PAPER  = 5;
  localparam int unsigned ST_ONLINE = 4;
  localparam int unsigned ST_NERR   = 3;
  localparam int unsigned ST_TMO    = 0;

  // control bit positions
  localparam int unsigned CT_DIR  = 5;
  localparam int unsigned CT_IEN  = 4;
  localparam int unsigned CT_SEL  = 3;
  localparam int unsigned CT_INIT = 2;
  localparam int unsigned CT_ALF  = 1;
  localparam int unsigned CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STAT_RST  = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h0C;
  localparam logic [BYTE_W-1:0] RD_FILL   = 8'hFF;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } ppt_sel_t;
endpackage

// File: rtl/ppt_addr_dec.sv
module ppt_addr_dec
  import ppt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ADDR_SHIFT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output ppt_sel_t          sel
);
  localparam int unsigned SPAN_W = IDX_W + ADDR_SHIFT;

  logic [ADDR_W-1:0] shifted;
  assign shifted = addr >> ADDR_SHIFT;
  assign sel.idx = shifted[IDX_W-1:0];

  generate
    if (ADDR_W > SPAN_W) begin : g_window
      // anything above the eight shifted locations is outside the window
      assign sel.hit = ~|addr[ADDR_W-1:SPAN_W];
    end else begin : g_full
      assign sel.hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ppt_hs_core.sv
module ppt_hs_core
  import ppt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] stat_view,
  output logic              send,
  output logic              irq
);
  logic [BYTE_W-1:0] stat_n;
  logic [BYTE_W-1:0] ctrl_n;
  logic              irq_q;

  always_comb begin
    stat_n = stat_q;
    ctrl_n = ctrl_q;
    send   = 1'b0;
    if (ctrl_wr) begin
      ctrl_n = wdata;
      if (!wdata[CT_INIT]) begin
        stat_n = STAT_INIT;
      end else if (wdata[CT_SEL] && wdata[CT_STB]) begin
        stat_n[ST_NBUSY] = 1'b0;
        send             = !ctrl_q[CT_STB];
      end
    end else if (stat_rd) begin
      if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_n[ST_ACK] = 1'b0;
        end else begin
          stat_n[ST_ACK]   = 1'b1;
          stat_n[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      ctrl_q <= CTRL_RST;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      ctrl_q <= ctrl_n;
      irq_q  <= ctrl_n[CT_IEN] & ~stat_n[ST_ACK];
    end
  end

  assign stat_view = stat_n;
  assign irq       = irq_q;

  // R4
  init_forces_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wdata[CT_INIT] |=> stat_q == STAT_INIT);

  // R7
  busy_read_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ctrl_wr && stat_q[ST_NBUSY] |=> $stable(stat_q));

  // R5
  send_leaves_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> ctrl_q[CT_STB] && !stat_q[ST_NBUSY]);
endmodule

// File: rtl/ppt_out_stage.sv
module ppt_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              room;

  assign room = !valid_q || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (push && room) begin
      valid_q <= 1'b1;
      data_q  <= push_data;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));
endmodule

// File: rtl/ppt_regif.sv
module ppt_regif
  import ppt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ADDR_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              irq
);
  ppt_sel_t          sel;
  logic              data_wr;
  logic              ctrl_wr;
  logic              stat_rd;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] stat_q;
  logic [BYTE_W-1:0] stat_view;
  logic              send;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q;

  ppt_addr_dec #(
    .ADDR_W    (ADDR_W),
    .ADDR_SHIFT(ADDR_SHIFT)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign data_wr = bus_wr && sel.hit && (sel.idx == IDX_DATA);
  assign ctrl_wr = bus_wr && sel.hit && (sel.idx == IDX_CTRL);
  assign stat_rd = bus_rd && sel.hit && (sel.idx == IDX_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= bus_wdata;
    end
  end

  ppt_hs_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .stat_rd  (stat_rd),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .stat_view(stat_view),
    .send     (send),
    .irq      (irq)
  );

  ppt_out_stage #(
    .DATA_W(BYTE_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (send),
    .push_data(data_q),
    .ready    (out_ready),
    .valid    (out_valid),
    .data     (out_data)
  );

  always_comb begin
    rd_mux = RD_FILL;
    if (sel.hit) begin
      case (sel.idx)
        IDX_DATA: rd_mux = ctrl_q[CT_DIR] ? in_data : data_q;
        IDX_STAT: rd_mux = stat_view;
        IDX_CTRL: rd_mux = ctrl_q;
        default:  rd_mux = RD_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  // R10
  unused_reads_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel.hit && (sel.idx > IDX_CTRL) |=> bus_rdata == 8'hFF);

  // R11
  outside_window_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !sel.hit |=> bus_rdata == 8'hFF);

  // R9
  stream_byte_from_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send && !out_valid |=> out_valid && (out_data == $past(data_q)));
endmodule

// File: tb/ppt_regif_tb.sv
`timescale 1ns/1ps
module ppt_regif_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned SH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [7:0]    in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  ppt_regif #(.ADDR_W(AW), .ADDR_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(input int idx);
    return AW'(idx << SH);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  // control write expected to emit the current data byte
  task automatic wr_send(input logic [7:0] ctrl, input logic [7:0] byte_exp);
    exp_q.push_back(byte_exp);
    wr(ra(2), ctrl);
  endtask

  // scoreboard monitor: looks just before the edge where a transfer happens
  always @(negedge clk) begin
    #5;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected stream byte", out_data, 8'h00);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R5 stream byte", out_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
    chk(out_valid == 1'b0, "R1 out_valid", {7'd0, out_valid}, 8'h00);
    rd(ra(1), 8'hD9, "R1 status");
    rd(ra(2), 8'h0C, "R1 control");

    // R2 data register both directions, R3 control readback
    wr(ra(0), 8'h5A);
    rd(ra(0), 8'h5A, "R2 data out");
    in_data = 8'hC3;
    wr(ra(2), 8'h2C);
    rd(ra(0), 8'hC3, "R2 data in");
    rd(ra(2), 8'h2C, "R3 control");
    wr(ra(2), 8'h0C);
    rd(ra(0), 8'h5A, "R2 data out again");

    // R5 strobe rising edge
    wr(ra(0), 8'h41);
    wr_send(8'h0D, 8'h41);
    rd(ra(1), 8'h59, "R5 busy cleared");
    rd(ra(1), 8'h59, "R7 strobe high no step");
    wr(ra(2), 8'h0D); // strobe already high: no second byte
    repeat (3) @(negedge clk);

    // R6 handshake steps
    wr(ra(2), 8'h0C);
    rd(ra(1), 8'h19, "R6 ack cleared");
    rd(ra(1), 8'hD9, "R6 ack and busy set");
    rd(ra(1), 8'hD9, "R7 busy set no step");

    // R8 interrupt
    wr(ra(2), 8'h1C);
    chk(irq == 1'b0, "R8 irq with ack set", {7'd0, irq}, 8'h00);
    wr(ra(0), 8'h42);
    wr_send(8'h1D, 8'h42);
    wr(ra(2), 8'h1C);
    rd(ra(1), 8'h19, "R6 ack cleared with enable");
    chk(irq == 1'b1, "R8 irq raised", {7'd0, irq}, 8'h01);
    rd(ra(1), 8'hD9, "R6 ack restored");
    chk(irq == 1'b0, "R8 irq dropped", {7'd0, irq}, 8'h00);
    wr(ra(1), 8'h19);
    wr(ra(2), 8'h0C);

    // R4 init clear
    wr(ra(2), 8'h08);
    rd(ra(1), 8'hD8, "R4 init forces status");
    wr(ra(2), 8'h0C);

    // R10 unused offsets and status writes
    wr(ra(3), 8'h00);
    wr(ra(7), 8'h00);
    wr(ra(1), 8'h00);
    rd(ra(3), 8'hFF, "R10 index 3");
    rd(ra(6), 8'hFF, "R10 index 6");
    rd(ra(1), 8'hD8, "R10 status kept");
    rd(ra(2), 8'h0C, "R10 control kept");
    rd(ra(0), 8'h42, "R10 data kept");

    // R11 address shift and window
    rd(AW'(5), 8'hD8, "R11 sub-stride address");
    rd(AW'(10), 8'h0C, "R11 control sub-stride");
    wr(AW'(32), 8'h00);
    rd(AW'(32), 8'hFF, "R11 outside window");
    rd(ra(0), 8'h42, "R11 outside write ignored");

    // R9 back-pressure
    @(negedge clk); out_ready = 1'b0;
    wr(ra(0), 8'h61);
    wr_send(8'h0D, 8'h61);
    chk(out_valid == 1'b1, "R9 valid raised", {7'd0, out_valid}, 8'h01);
    chk(out_data == 8'h61, "R9 data presented", out_data, 8'h61);
    rd(ra(1), 8'h58, "R5 busy cleared from init state");
    wr(ra(2), 8'h0C);
    wr(ra(0), 8'h62);
    wr(ra(2), 8'h0D); // dropped: earlier byte still waiting
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid held", {7'd0, out_valid}, 8'h01);
    chk(out_data == 8'h61, "R9 data held", out_data, 8'h61);
    @(negedge clk); out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid cleared", {7'd0, out_valid}, 8'h00);
    chk(exp_q.size() == 0, "R9 all bytes delivered", 8'(exp_q.size()), 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule